// File: doc/BRIEF.md
# Prescaled Down-Counter Timer Channel

This block is a single timer channel for a memory-mapped peripheral. It contains a down-counter that runs at either 16-bit or 32-bit width, with a clock prescaler in front of it. The prescaler counts pulses of a timer-clock enable. The channel can run free, reload periodically, or fire once and stop. When a decrement brings the counter to zero, it raises an interrupt. It provides raw and masked interrupt status, and an interrupt request line that follows the masked status.

The surrounding peripheral decodes the bus and turns accesses into one-cycle strobes: a primary load write, a background load write, a control write and an interrupt clear. All of them share one write-data bus. Readback values for the load, the live count, the control word and both status flags come out continuously, so the peripheral can multiplex them onto its read bus. If several events fall in the same clock cycle, they resolve in this order: counter step first, then primary load, then background load, then control. A later item overrides an earlier one wherever both touch the same state.

Top module: `prescaled_countdown_timer`

## Requirements
- R1: After reset, the control readback is 0x20, the load readback is 0, the count readback is 0xFFFFFFFF, and raw status, masked status and irq are all 0.
- R2: A control write keeps these bits: bit7 enable, bit6 periodic (1) or free-running (0), bit5 interrupt enable, bits[3:2] prescale code, bit1 width (1 = 32-bit, 0 = 16-bit) and bit0 one-shot. Bit 4 and every bit above bit 7 read back as zero.
- R3: The counter moves by one for every 1, 16 or 256 timer-clock enable pulses, for prescale codes 00, 01, and 10/11 respectively. The prescaler restarts from zero whenever a control write changes the prescale code. With enable at 0, the count does not move.
- R4: A primary load write sets both the load readback and the count readback to the full 32-bit write data in the next cycle.
- R5: A background load write changes only the load value. The count keeps running, and the next reload uses the new value.
- R6: In free-running mode, a step taken at zero wraps the active part of the count to 0xFFFF (16-bit) or 0xFFFFFFFF (32-bit). The load value has no effect on the wrap.
- R7: In periodic mode, a step taken at zero reloads the active part of the count from the load value. In 16-bit mode the value is truncated to its low 16 bits.
- R8: Raw status is set only when a decrement reaches zero. Loading zero, or stepping while already at zero, does not set it.
- R9: In one-shot mode the counter halts once it reaches zero. It restarts after a primary load of a nonzero value, or after a control write with enable at 1 and one-shot at 0.
- R10: A primary load write whose active value is zero, made in periodic mode, halts the counter at zero.
- R11: An int_clr strobe clears raw status, but an expiry in the same cycle wins. Masked status and irq equal raw status ANDed with the interrupt-enable bit.
- R12: In 16-bit mode the upper 16 bits of the count readback stay unchanged while the lower 16 bits count, wrap and reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer-clock enable pulse, counted by the prescaler |
| wr_load | input | 1 | Primary load write strobe (reloads the count at once) |
| wr_bgload | input | 1 | Background load write strobe (reload value only) |
| wr_ctrl | input | 1 | Control write strobe |
| wdata | input | CNT_W | Write data shared by all write strobes |
| int_clr | input | 1 | Raw interrupt status clear strobe |
| rd_load | output | CNT_W | Load value readback |
| rd_count | output | CNT_W | Current count readback |
| rd_ctrl | output | CNT_W | Control readback, unused bits zero |
| rd_raw | output | 1 | Raw interrupt status |
| rd_masked | output | 1 | Raw status gated by interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check properties that hold on every cycle: unused control bits read zero, a primary load lands on both readbacks, a background load leaves the count alone, the count is frozen while disabled, a halted one-shot stays at zero, and raw status only rises at a zero count. The bench's scenarios are needed for behaviour that spans many cycles: exact prescale ratios and the prescaler restart, wrap versus reload values, upper-half preservation in 16-bit mode, restarting an expired one-shot, and set-versus-clear priority in a single cycle. A behavioural reference model compares every readback on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned CTRL_W     = 8;
    localparam int unsigned B_ONESHOT  = 0;
    localparam int unsigned B_SIZE     = 1;
    localparam int unsigned B_PRE_LO   = 2;
    localparam int unsigned B_INTEN    = 5;
    localparam int unsigned B_PERIODIC = 6;
    localparam int unsigned B_EN       = 7;

    // Writable control bits; bit 4 is not implemented.
    localparam logic [CTRL_W-1:0] CTRL_KEEP  = 8'hEF;
    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

    typedef enum logic [1:0] {
        PRE_DIV1   = 2'b00,
        PRE_DIV16  = 2'b01,
        PRE_DIV256 = 2'b10,
        PRE_ODD    = 2'b11
    } pre_code_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned MID_SHIFT  = 4,
    parameter int unsigned HIGH_SHIFT = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] code,
    output logic       step
);
    import tmr_pkg::*;

    localparam int unsigned PRE_W = HIGH_SHIFT;
    localparam logic [PRE_W-1:0] TERM_MID  = PRE_W'((1 << MID_SHIFT) - 1);
    localparam logic [PRE_W-1:0] TERM_HIGH = PRE_W'((1 << HIGH_SHIFT) - 1);

    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] terminal;

    always_comb begin
        case (pre_code_e'(code))
            PRE_DIV1:  terminal = '0;
            PRE_DIV16: terminal = TERM_MID;
            default:   terminal = TERM_HIGH;   // 10 and the undefined 11
        endcase
        step  = tick_en && run && (cnt_q == terminal);
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (tick_en && run) begin
            cnt_d = step ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tmr_irq_status.sv
module tmr_irq_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic inten,
    output logic raw,
    output logic masked
);
    logic raw_d, raw_q;

    always_comb begin
        raw_d = raw_q;
        if (clr) raw_d = 1'b0;
        if (set) raw_d = 1'b1;   // expiry wins over a simultaneous clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw_d;
    end

    assign raw    = raw_q;
    assign masked = raw_q & inten;

endmodule

// File: rtl/prescaled_countdown_timer.sv
module prescaled_countdown_timer #(
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned HALF_W     = 16,
    parameter int unsigned MID_SHIFT  = 4,
    parameter int unsigned HIGH_SHIFT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             wr_load,
    input  logic             wr_bgload,
    input  logic             wr_ctrl,
    input  logic [CNT_W-1:0] wdata,
    input  logic             int_clr,
    output logic [CNT_W-1:0] rd_load,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] rd_ctrl,
    output logic             rd_raw,
    output logic             rd_masked,
    output logic             irq
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] ALL_ONES  = '1;
    localparam logic [CNT_W-1:0] HALF_ONES = CNT_W'({HALF_W{1'b1}});

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [CNT_W-1:0]  load;
        logic [CNT_W-1:0]  count;
        logic              halt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic             step;
    logic             expire;
    logic             pre_restart;
    logic             size32, periodic, oneshot;
    logic [CNT_W-1:0] cur_low, new_low, reload_v, load_act;

    tmr_prescaler #(
        .MID_SHIFT  (MID_SHIFT),
        .HIGH_SHIFT (HIGH_SHIFT)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (st_q.ctrl[B_EN]),
        .restart (pre_restart),
        .code    (st_q.ctrl[B_PRE_LO +: 2]),
        .step    (step)
    );

    always_comb begin
        st_d     = st_q;
        expire   = 1'b0;
        size32   = st_q.ctrl[B_SIZE];
        periodic = st_q.ctrl[B_PERIODIC];
        oneshot  = st_q.ctrl[B_ONESHOT];

        // Active part of the count and the value a step at zero leads to.
        cur_low  = size32 ? st_q.count : (st_q.count & HALF_ONES);
        reload_v = periodic ? (size32 ? st_q.load : (st_q.load & HALF_ONES))
                            : (size32 ? ALL_ONES : HALF_ONES);
        load_act = size32 ? wdata : (wdata & HALF_ONES);
        new_low  = cur_low;

        if (step && !st_q.halt) begin
            if (cur_low == '0) begin
                if (oneshot) st_d.halt = 1'b1;
                else         new_low   = reload_v;
            end else begin
                new_low = cur_low - 1'b1;
                if (new_low == '0) begin
                    expire = 1'b1;
                    if (oneshot) st_d.halt = 1'b1;
                end
            end
        end
        st_d.count = size32 ? new_low
                            : ((st_q.count & ~HALF_ONES) | (new_low & HALF_ONES));

        if (wr_load) begin
            st_d.load  = wdata;
            st_d.count = wdata;
            if (periodic && (load_act == '0)) st_d.halt = 1'b1;
            else if (load_act != '0)          st_d.halt = 1'b0;
        end

        if (wr_bgload) begin
            st_d.load = wdata;
        end

        if (wr_ctrl) begin
            st_d.ctrl = wdata[CTRL_W-1:0] & CTRL_KEEP;
            if (wdata[B_EN] && !wdata[B_ONESHOT]) st_d.halt = 1'b0;
        end

        pre_restart = wr_ctrl && (wdata[B_PRE_LO +: 2] != st_q.ctrl[B_PRE_LO +: 2]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RESET;
            st_q.load  <= '0;
            st_q.count <= ALL_ONES;
            st_q.halt  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    tmr_irq_status u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (expire),
        .clr    (int_clr),
        .inten  (st_q.ctrl[B_INTEN]),
        .raw    (rd_raw),
        .masked (rd_masked)
    );

    assign rd_load  = st_q.load;
    assign rd_count = st_q.count;
    assign rd_ctrl  = CNT_W'(st_q.ctrl);
    assign irq      = rd_masked;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned HALF_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_load,
    input logic             wr_bgload,
    input logic             wr_ctrl,
    input logic [CNT_W-1:0] wdata,
    input logic             int_clr,
    input logic [CNT_W-1:0] rd_load,
    input logic [CNT_W-1:0] rd_count,
    input logic [CNT_W-1:0] rd_ctrl,
    input logic             rd_raw
);
    logic at_zero;
    assign at_zero = rd_ctrl[1] ? (rd_count == '0) : (rd_count[HALF_W-1:0] == '0);

    // R2
    ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl[CNT_W-1:8] == '0) && !rd_ctrl[4]);

    // R4
    load_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (rd_count == $past(wdata)) && (rd_load == $past(wdata)));

    // R5
    bgload_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bgload && !wr_load && !rd_ctrl[7]) |=> (rd_load == $past(wdata)) && $stable(rd_count));

    // R3
    disabled_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ctrl[7] && !wr_load) |=> $stable(rd_count));

    // R9
    oneshot_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl[7] && rd_ctrl[0] && at_zero && !wr_load && !wr_ctrl) |=> at_zero);

    // R8
    raw_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_raw) && !$past(wr_ctrl) && !$past(wr_load)) |-> at_zero);

    // R11
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_clr && !rd_ctrl[7]) |=> !rd_raw);

endmodule

bind prescaled_countdown_timer tmr_checker #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_load   (wr_load),
    .wr_bgload (wr_bgload),
    .wr_ctrl   (wr_ctrl),
    .wdata     (wdata),
    .int_clr   (int_clr),
    .rd_load   (rd_load),
    .rd_count  (rd_count),
    .rd_ctrl   (rd_ctrl),
    .rd_raw    (rd_raw)
);

// File: tb/prescaled_countdown_timer_test.sv
`timescale 1ns/1ps
module prescaled_countdown_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        wr_load = 1'b0;
    logic        wr_bgload = 1'b0;
    logic        wr_ctrl = 1'b0;
    logic [31:0] wdata = '0;
    logic        int_clr = 1'b0;
    logic [31:0] rd_load, rd_count, rd_ctrl;
    logic        rd_raw, rd_masked, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    prescaled_countdown_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_load(wr_load),
        .wr_bgload(wr_bgload), .wr_ctrl(wr_ctrl), .wdata(wdata), .int_clr(int_clr),
        .rd_load(rd_load), .rd_count(rd_count), .rd_ctrl(rd_ctrl),
        .rd_raw(rd_raw), .rd_masked(rd_masked), .irq(irq)
    );

    // Behavioural reference state
    logic [31:0] m_ctrl = 32'h20, m_load = 0, m_count = 32'hFFFFFFFF;
    int          m_pre = 0;
    bit          m_halt = 0, m_raw = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 32'h20; m_load = 0; m_count = 32'hFFFFFFFF;
            m_pre = 0; m_halt = 0; m_raw = 0;
        end else begin
            int     div;
            bit     stp, setr, is32, per, one, en;
            longint lo, nlo, act;
            is32 = m_ctrl[1]; per = m_ctrl[6]; one = m_ctrl[0]; en = m_ctrl[7];
            div = (m_ctrl[3:2] == 0) ? 1 : (m_ctrl[3:2] == 1) ? 16 : 256;
            stp = tick_en && en && (m_pre == div - 1);
            if (wr_ctrl && (wdata[3:2] != m_ctrl[3:2])) m_pre = 0;
            else if (tick_en && en) m_pre = stp ? 0 : m_pre + 1;
            setr = 0;
            lo = is32 ? m_count : (m_count % 65536);
            nlo = lo;
            if (stp && !m_halt) begin
                if (lo == 0) begin
                    if (one) m_halt = 1;
                    else if (per) nlo = is32 ? m_load : (m_load % 65536);
                    else nlo = is32 ? 32'hFFFFFFFF : 65535;
                end else begin
                    nlo = lo - 1;
                    if (nlo == 0) begin setr = 1; if (one) m_halt = 1; end
                end
            end
            if (is32) m_count = nlo[31:0];
            else m_count = {m_count[31:16], nlo[15:0]};
            if (int_clr) m_raw = 0;
            if (setr) m_raw = 1;
            if (wr_load) begin
                act = is32 ? wdata : (wdata % 65536);
                m_load = wdata; m_count = wdata;
                if (per && act == 0) m_halt = 1;
                else if (act != 0) m_halt = 0;
            end
            if (wr_bgload) m_load = wdata;
            if (wr_ctrl) begin
                m_ctrl = wdata & 32'hEF;
                if (wdata[7] && !wdata[0]) m_halt = 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Cycle-by-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model ctrl",    rd_ctrl,   m_ctrl);
            chk("R4 model load",    rd_load,   m_load);
            chk("R3 model count",   rd_count,  m_count);
            chk("R8 model raw",     {31'b0, rd_raw},    {31'b0, m_raw});
            chk("R11 model masked", {31'b0, rd_masked}, {31'b0, m_raw & m_ctrl[5]});
            chk("R11 model irq",    {31'b0, irq},       {31'b0, m_raw & m_ctrl[5]});
        end
    end

    task automatic wr(input int kind, input logic [31:0] d);
        @(negedge clk);
        wdata = d;
        wr_load = (kind == 0); wr_bgload = (kind == 1); wr_ctrl = (kind == 2);
        @(negedge clk);
        wr_load = 0; wr_bgload = 0; wr_ctrl = 0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1;
        repeat (n) @(negedge clk);
        tick_en = 0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        int_clr = 1;
        @(negedge clk);
        int_clr = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset ctrl",  rd_ctrl,  32'h20);
        chk("R1 reset load",  rd_load,  32'h0);
        chk("R1 reset count", rd_count, 32'hFFFFFFFF);
        chk("R1 reset irq",   {29'b0, rd_raw, rd_masked, irq}, 32'h0);
        rst_n = 1;

        wr(2, 32'hFFFFFF10);
        chk("R2 unused ctrl bits", rd_ctrl, 32'h0);

        // free-running 16-bit, upper half preserved
        wr(0, 32'h12340003);
        chk("R4 load count", rd_count, 32'h12340003);
        wr(2, 32'hA0);
        ticks(3);
        chk("R8 expiry count", rd_count, 32'h12340000);
        chk("R8 expiry irq", {30'b0, rd_raw, irq}, 32'h3);
        ticks(1);
        chk("R6 R12 wrap16", rd_count, 32'h1234FFFF);
        clr_pulse();
        chk("R11 cleared", {31'b0, rd_raw}, 32'h0);

        // periodic 32-bit with background load
        wr(2, 32'hE2);
        wr(0, 32'h2);
        ticks(3);
        chk("R7 reload", rd_count, 32'h2);
        wr(1, 32'h5);
        chk("R5 bg count kept", rd_count, 32'h2);
        chk("R5 bg load", rd_load, 32'h5);
        ticks(3);
        chk("R5 bg reload", rd_count, 32'h5);
        clr_pulse();

        // one-shot halt and restart
        wr(2, 32'hA3);
        wr(0, 32'h2);
        ticks(7);
        chk("R9 oneshot halted", rd_count, 32'h0);
        wr(2, 32'hA2);
        ticks(1);
        chk("R9 restart wraps", rd_count, 32'hFFFFFFFF);
        clr_pulse();

        // periodic zero load halts and raises nothing
        wr(2, 32'hE2);
        wr(0, 32'h0);
        ticks(4);
        chk("R10 zero halts", rd_count, 32'h0);
        chk("R8 no irq on zero load", {31'b0, rd_raw}, 32'h0);

        // prescaler ratios and restart
        wr(2, 32'h26);
        wr(0, 32'd100);
        wr(2, 32'hA6);
        ticks(32);
        chk("R3 div16", rd_count, 32'd98);
        ticks(15);
        chk("R3 div16 partial", rd_count, 32'd98);
        wr(2, 32'hAE);
        ticks(255);
        chk("R3 div256 restart", rd_count, 32'd98);
        ticks(1);
        chk("R3 div256 step", rd_count, 32'd97);
        wr(2, 32'h2E);
        ticks(300);
        chk("R3 disabled frozen", rd_count, 32'd97);

        // masking and set-over-clear
        wr(2, 32'h82);
        wr(0, 32'h1);
        ticks(1);
        chk("R11 masked off", {29'b0, rd_raw, rd_masked, irq}, 32'h4);
        wr(0, 32'h1);
        @(negedge clk);
        tick_en = 1; int_clr = 1;
        @(negedge clk);
        tick_en = 0; int_clr = 0;
        chk("R11 set wins", {31'b0, rd_raw}, 32'h1);
        clr_pulse();
        chk("R11 clear", {31'b0, rd_raw}, 32'h0);

        // periodic 16-bit reload truncation
        wr(2, 32'hE0);
        wr(0, 32'h55550001);
        ticks(1);
        chk("R8 expire16", rd_count, 32'h55550000);
        wr(1, 32'hABCD0003);
        ticks(1);
        chk("R7 R12 reload16", rd_count, 32'h55550003);
        chk("R5 load16", rd_load, 32'hABCD0003);

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule